// File: doc/BRIEF.md
# Partitioned Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of equal width and returns the full double-width signed product. An input strobe marks a valid operand pair. One clock later the product register and an output strobe show the result. The block is meant for datapaths where many operands sit near zero. In that case, radix-4 recoding of a narrow-range multiplier gives mostly zero digits, so fewer partial-product bits toggle.

Two mechanisms make zero digits more likely. First, before recoding, the block measures how many significant bits each operand really uses. The operand with the narrower range drives the recoded side, and the other operand becomes the multiplicand. Second, the recoded operand is cut into equal slices. Each slice is recoded and multiplied by the multiplicand on its own. The slice products are then shifted to their bit positions and added.

Top module: `booth_part_mult`

## Requirements
- R1: One clock edge after `in_valid` is high, `product` holds the exact signed product of `op_a` and `op_b` as seen at that edge, as a 2*WIDTH-bit two's-complement value.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. While `rst_n` is low, `out_valid` and `product` are 0.
- R3: While `in_valid` is low, `product` keeps its previous value.
- R4: The effective range of an operand is WIDTH minus its redundant leading sign bits. A redundant sign bit is a bit directly below the MSB that equals the MSB, counted while the run continues. The recoded (multiplier) side receives `op_b` only when `op_b` has a strictly smaller range than `op_a`. On a tie, or otherwise, it receives `op_a`.
- R5: For any operand pair, the result for (`op_a`, `op_b`) equals the result for the swapped pair (`op_b`, `op_a`).
- R6: The multiplier is split into WIDTH/SEG_W slices of SEG_W bits each. The top slice is recoded as signed. Every lower slice is recoded as unsigned, with zero bits appended above its MSB. Each slice product is shifted left by (slice index × SEG_W) before summation. Operands whose lower-slice MSB is 1 (for example 0x0080 with SEG_W = 8) must still give the exact product.
- R7: Every recoding triplet whose three bits are equal (000 or 111) yields digit 0 and a partial product of all zeros.
- R8: The extreme cases are exact. With WIDTH = 16, (-32768) × (-32768) gives 0x40000000, and (-32768) × (-1) gives 0x00008000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid strobe |
| op_a | input | WIDTH | Signed operand A |
| op_b | input | WIDTH | Signed operand B |
| out_valid | output | 1 | Product valid strobe, one cycle after `in_valid` |
| product | output | 2*WIDTH | Registered signed product |

## Verification
The bench builds two copies side by side, both with WIDTH = 16. One uses the default SEG_W = 8, so it has two slices. The other uses SEG_W = 4, so it has four slices, three of them unsigned. This second copy shows whether carries between slices and the zero-extended unsigned recoding stay correct when the slice count grows. The stimulus mixes full-range random operands with operands shrunk by arithmetic shifts. This reaches both swap outcomes, range ties, and long runs of all-equal triplets inside each slice.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } booth_dig_e;

    // Radix-4 recoding of the triplet {y[2i+1], y[2i], y[2i-1]}
    function automatic booth_dig_e recode(input logic [2:0] trip);
        booth_dig_e d;
        case (trip)
            3'b001, 3'b010: d = DIG_POS1;
            3'b011:         d = DIG_POS2;
            3'b100:         d = DIG_NEG2;
            3'b101, 3'b110: d = DIG_NEG1;
            default:        d = DIG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lead_range.sv
module lead_range #(
    parameter int W  = 16,
    parameter int RW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [RW-1:0] range_o
);

    logic [RW-1:0] redund;

    always_comb begin
        logic run;
        run    = 1'b1;
        redund = '0;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (val[i] == val[W-1])) begin
                redund = redund + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

    assign range_o = RW'(W) - redund;

endmodule

// File: rtl/operand_steer.sv
module operand_steer #(
    parameter int W  = 16,
    parameter int RW = $clog2(W + 1)
) (
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    output logic [W-1:0]  mplier,
    output logic [W-1:0]  mcand,
    output logic          swap,
    output logic [RW-1:0] rng_a,
    output logic [RW-1:0] rng_b
);

    lead_range #(.W(W), .RW(RW)) u_rng_a (.val(op_a), .range_o(rng_a));
    lead_range #(.W(W), .RW(RW)) u_rng_b (.val(op_b), .range_o(rng_b));

    // strict compare: a tie leaves op_a on the recoded side
    assign swap   = (rng_b < rng_a);
    assign mplier = swap ? op_b : op_a;
    assign mcand  = swap ? op_a : op_b;

endmodule

// File: rtl/booth_segment.sv
module booth_segment
    import booth_pkg::*;
#(
    parameter int MC_W       = 16,
    parameter int SEG_W      = 8,
    parameter bit SIGNED_SEG = 1'b0,
    parameter int OUT_W      = 32,
    parameter int ND_U       = SEG_W / 2 + 1
) (
    input  logic [MC_W-1:0]  mcand,
    input  logic [SEG_W-1:0] seg,
    output logic [OUT_W-1:0] prod,
    output logic [ND_U-1:0]  dig_zero,
    output logic [ND_U-1:0]  pp_zero
);

    localparam int EXT_W = SIGNED_SEG ? SEG_W : SEG_W + 2;
    localparam int ND    = EXT_W / 2;

    logic [EXT_W:0]   ybits;
    logic [OUT_W-1:0] mc_ext;
    logic [OUT_W-1:0] pp [ND];
    logic [ND-1:0]    dz;
    logic [ND-1:0]    pz;

    assign mc_ext = {{(OUT_W - MC_W){mcand[MC_W-1]}}, mcand};

    generate
        if (SIGNED_SEG) begin : g_sext
            assign ybits = {seg, 1'b0};
        end else begin : g_zext
            assign ybits = {2'b00, seg, 1'b0};
        end
    endgenerate

    for (genvar i = 0; i < ND; i++) begin : g_dig
        booth_dig_e       dig;
        logic [OUT_W-1:0] base;
        logic             neg;
        logic [2:0]       trip;

        assign trip = ybits[2*i+2 -: 3];
        assign dig  = recode(trip);

        always_comb begin
            unique case (dig)
                DIG_POS1, DIG_NEG1: base = mc_ext;
                DIG_POS2, DIG_NEG2: base = mc_ext << 1;
                default:            base = '0;
            endcase
        end

        assign neg   = (dig == DIG_NEG1) || (dig == DIG_NEG2);
        assign pp[i] = neg ? (((~base) << (2*i)) + (OUT_W'(1) << (2*i)))
                           : (base << (2*i));
        assign dz[i] = (trip == 3'b000) || (trip == 3'b111);
        assign pz[i] = (pp[i] == '0);
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < ND; i++) begin
            prod = prod + pp[i];
        end
    end

    generate
        if (ND < ND_U) begin : g_pad
            assign dig_zero = {1'b0, dz};
            assign pp_zero  = {1'b1, pz};
        end else begin : g_full
            assign dig_zero = dz;
            assign pp_zero  = pz;
        end
    endgenerate

endmodule

// File: rtl/booth_part_mult.sv
module booth_part_mult #(
    parameter int WIDTH = 16,
    parameter int SEG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW    = 2 * WIDTH;
    localparam int NSEG  = WIDTH / SEG_W;
    localparam int RNG_W = $clog2(WIDTH + 1);
    localparam int ND_U  = SEG_W / 2 + 1;
    localparam int ZB_W  = NSEG * ND_U;

    logic [WIDTH-1:0] mplier;
    logic [WIDTH-1:0] mcand;
    logic             swap;
    logic [RNG_W-1:0] rng_a;
    logic [RNG_W-1:0] rng_b;
    logic [PW-1:0]    seg_prod [NSEG];
    logic [ZB_W-1:0]  dig_zero;
    logic [ZB_W-1:0]  pp_zero;
    logic [PW-1:0]    sum_c;

    operand_steer #(.W(WIDTH), .RW(RNG_W)) u_steer (
        .op_a   (op_a),
        .op_b   (op_b),
        .mplier (mplier),
        .mcand  (mcand),
        .swap   (swap),
        .rng_a  (rng_a),
        .rng_b  (rng_b)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        booth_segment #(
            .MC_W       (WIDTH),
            .SEG_W      (SEG_W),
            .SIGNED_SEG (s == NSEG - 1),
            .OUT_W      (PW),
            .ND_U       (ND_U)
        ) u_seg (
            .mcand    (mcand),
            .seg      (mplier[s*SEG_W +: SEG_W]),
            .prod     (seg_prod[s]),
            .dig_zero (dig_zero[s*ND_U +: ND_U]),
            .pp_zero  (pp_zero[s*ND_U +: ND_U])
        );
    end

    always_comb begin
        sum_c = '0;
        for (int s = 0; s < NSEG; s++) begin
            sum_c = sum_c + (seg_prod[s] << (s * SEG_W));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                product <= sum_c;
            end
        end
    end

endmodule

// File: rtl/booth_part_mult_chk.sv
module booth_part_mult_chk #(
    parameter int WIDTH = 16,
    parameter int RW    = 5,
    parameter int NZ    = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               out_valid,
    input logic [2*WIDTH-1:0] product,
    input logic               swap,
    input logic [RW-1:0]      rng_a,
    input logic [RW-1:0]      rng_b,
    input logic [WIDTH-1:0]   mplier,
    input logic [WIDTH-1:0]   mcand,
    input logic [NZ-1:0]      dig_zero,
    input logic [NZ-1:0]      pp_zero
);

    function automatic logic [2*WIDTH-1:0] ref_mul(input logic [WIDTH-1:0] a,
                                                   input logic [WIDTH-1:0] b);
        logic signed [2*WIDTH-1:0] xa;
        logic signed [2*WIDTH-1:0] xb;
        xa = {{WIDTH{a[WIDTH-1]}}, a};
        xb = {{WIDTH{b[WIDTH-1]}}, b};
        return xa * xb;
    endfunction

    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product == ref_mul($past(op_a), $past(op_b)));

    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    assert_swap_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> (rng_b < rng_a) && (mplier == op_b) && (mcand == op_a));

    assert_tie_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_a <= rng_b) |-> !swap && (mplier == op_a) && (mcand == op_b));

    assert_range_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_a >= RW'(1)) && (rng_a <= RW'(WIDTH)) &&
        (rng_b >= RW'(1)) && (rng_b <= RW'(WIDTH)));

    assert_zero_pp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_zero & ~pp_zero) == '0);

endmodule

bind booth_part_mult booth_part_mult_chk #(
    .WIDTH (WIDTH),
    .RW    (RNG_W),
    .NZ    (ZB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product),
    .swap      (swap),
    .rng_a     (rng_a),
    .rng_b     (rng_b),
    .mplier    (mplier),
    .mcand     (mcand),
    .dig_zero  (dig_zero),
    .pp_zero   (pp_zero)
);

// File: tb/tb_booth_part_mult.sv
module tb_booth_part_mult;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          ov8;
    logic          ov4;
    logic [2*W-1:0] p8;
    logic [2*W-1:0] p4;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    booth_part_mult #(.WIDTH(W), .SEG_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(ov8), .product(p8)
    );

    booth_part_mult #(.WIDTH(W), .SEG_W(4)) dut_fine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(ov4), .product(p4)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] xa;
        logic signed [2*W-1:0] xb;
        xa = {{W{a[W-1]}}, a};
        xb = {{W{b[W-1]}}, b};
        return xa * xb;
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive a pair for one cycle, check both builds at the next falling edge
    task automatic mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, p8, ref_mul(a, b));
        check(req, p4, ref_mul(a, b));
        check({req, " valid R2"}, {31'd0, ov8 & ov4}, 32'd1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("reset R2 product", p8, '0);
        check("reset R2 valid", {31'd0, ov8 | ov4}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("idle R2 valid low", {31'd0, ov8 | ov4}, 32'd0);

        // R8 extremes
        mul(16'h8000, 16'h8000, "R8 min*min");
        check("R8 min*min literal", p8, 32'h40000000);
        mul(16'h8000, 16'hFFFF, "R8 min*-1");
        check("R8 min*-1 literal", p8, 32'h00008000);
        mul(16'hFFFF, 16'h8000, "R8 -1*min");
        mul(16'h7FFF, 16'h8000, "R8 max*min");
        mul(16'h7FFF, 16'h7FFF, "R8 max*max");

        // R6 lower-slice MSB set, unsigned slice recoding
        mul(16'h0080, 16'h1234, "R6 low msb");
        mul(16'h1234, 16'h0080, "R6 low msb swapped");
        mul(16'h0088, 16'hF00F, "R6 four-slice msbs");
        mul(16'hFF7F, 16'h00FF, "R6 neg with low msb");

        // R7 all-equal triplets: zeros and ones
        mul(16'h0000, 16'h5A5A, "R7 zero");
        mul(16'hFFFF, 16'h5A5A, "R7 minus one");
        mul(16'h00FF, 16'hFF00, "R7 runs");

        // R4 / R5 tie and swap orderings
        mul(16'h0003, 16'h0002, "R4 tie");
        mul(16'h0002, 16'h0003, "R4 tie rev");
        mul(16'h0005, 16'h7123, "R5 small a");
        mul(16'h7123, 16'h0005, "R5 small b");
        check("R5 order independent", p8, ref_mul(16'h0005, 16'h7123));

        // R3 hold while idle
        held = p8;
        op_a = 16'h1111;
        op_b = 16'h2222;
        repeat (3) @(negedge clk);
        check("R3 hold", p8, held);
        check("R3 hold fine", p4, held);
        check("R3 valid low R2", {31'd0, ov8 | ov4}, 32'd0);

        // R1 random, with range narrowing
        for (int k = 0; k < 1500; k++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = W'($urandom);
            a = W'($signed(a) >>> ($urandom % W));
            b = W'($signed(b) >>> ($urandom % W));
            mul(a, b, "R1 random");
            if (k % 4 == 0) begin
                mul(b, a, "R5 random swap");
            end
        end

        // R1 back-to-back valid cycles
        @(negedge clk);
        in_valid = 1'b1;
        op_a = 16'h8001;
        op_b = 16'h0041;
        @(negedge clk);
        check("R1 b2b first", p8, ref_mul(16'h8001, 16'h0041));
        op_a = 16'h0041;
        op_b = 16'h8001;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b second", p4, ref_mul(16'h0041, 16'h8001));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule